// File: doc/BRIEF.md
# NAND Block Hamming Check-Code Generator

This block streams over one 256-byte data block, one byte per accepted cycle, and produces a three-byte Hamming check code. The code supports locating and fixing one flipped bit in the block, and spotting a second one, when the block is read back. The generator only produces the code. It does no correction and has no flash interface. A 512-byte flash page is treated as two separate blocks, each with its own start, so each page yields six code bytes.

A block begins with a start strobe. The block keeps the byte index itself. Each accepted byte updates one parity bit per byte-index partition: a "set" and a "clear" partition for every index bit. It also updates a byte-wide column accumulator. When the last byte of the block is accepted, the block raises a one-cycle done pulse and registers the code. The code stays on the outputs until the next block completes.

Top module: `nand_hamming_gen`

## Requirements
- R1: Code byte 0 is `row_code_o[7:0]` and code byte 1 is `row_code_o[15:8]`. Bit 2k+1 is the bit-parity of all bytes whose index has bit k set. Bit 2k is the bit-parity of all bytes whose index has bit k clear.
- R2: The column accumulator is the XOR of all block bytes. Code byte 2 is `col_code_o`. Its bits 7, 6, 5, 4, 3 and 2 hold the parity of that accumulator ANDed with 0xF0, 0x0F, 0xCC, 0x33, 0xAA and 0x55 respectively.
- R3: `col_code_o[1]` is always 0. `col_code_o[0]` is the parity of the whole column accumulator.
- R4: The code is not inverted, so a block of 256 bytes of 0xFF gives 00:00:00.
- R5: `start_i` clears all accumulators and the byte index. With `valid_i` high in the same cycle, that byte is index 0. Without it, the next accepted byte is index 0.
- R6: In a cycle with `valid_i` low, `data_i` has no effect on the code.
- R7: `done_o` is high for exactly one cycle: the cycle after the 256th byte of a block is accepted.
- R8: The code outputs change only in the cycle in which `done_o` is high. They hold in every other cycle.
- R9: After a block completes, bytes offered without a new `start_i` are ignored. No further done pulse occurs.
- R10: After reset, `done_o` is 0 and both code outputs are 0.
- R11: A `start_i` in the middle of a block drops the partial block. The next code covers only the bytes that follow the new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start of a new block |
| valid_i | input | 1 | `data_i` holds a block byte this cycle |
| data_i | input | 8 | Block byte |
| done_o | output | 1 | One-cycle pulse when a code is ready |
| row_code_o | output | 2*IDX_BITS | Row partition parities (code bytes 0 and 1) |
| col_code_o | output | 8 | Column code (code byte 2) |

## Verification
Blocks of all 0xFF and all 0x00 check that the code is not inverted. A block of rising byte values exercises every row and column term together. A sweep places one set bit in each of the 256 positions in turn, with the bit lane rotating. This ties each byte index to its own row-parity pattern and each bit lane to its column bits, so a swapped or misplaced term shows up. Pseudo-random blocks with idle gaps carrying junk data separate valid-gated capture from free-running capture. Three further patterns separate correct block framing from wrapping or stale state: a lone start with no byte, a restart in the middle of a block, and a long run of bytes after completion.

// File: rtl/nand_hamming_gen.sv
module nand_hamming_gen #(
  parameter int IDX_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  valid_i,
  input  logic [7:0]            data_i,
  output logic                  done_o,
  output logic [2*IDX_BITS-1:0] row_code_o,
  output logic [7:0]            col_code_o
);

  localparam int ROW_W = 2 * IDX_BITS;
  localparam logic [IDX_BITS-1:0] LAST_IDX = '1;

  logic                open_q;
  logic [IDX_BITS-1:0] idx_q;
  logic [ROW_W-1:0]    row_q, row_nxt, row_code_q;
  logic [7:0]          col_q, col_nxt, col_code_q;
  logic                done_q;

  function automatic logic [7:0] fold_col(input logic [7:0] c);
    return {^(c & 8'hF0), ^(c & 8'h0F), ^(c & 8'hCC), ^(c & 8'h33),
            ^(c & 8'hAA), ^(c & 8'h55), 1'b0, ^c};
  endfunction

  wire                take     = valid_i & (start_i | open_q);
  wire [IDX_BITS-1:0] idx_cur  = start_i ? '0 : idx_q;
  wire [ROW_W-1:0]    row_base = start_i ? '0 : row_q;
  wire [7:0]          col_base = start_i ? 8'h00 : col_q;
  wire                hit      = take & (^data_i);
  wire                last     = take & (idx_cur == LAST_IDX);

  genvar k;
  generate
    for (k = 0; k < IDX_BITS; k++) begin : g_row
      assign row_nxt[2*k+1] = row_base[2*k+1] ^ (hit &  idx_cur[k]);
      assign row_nxt[2*k]   = row_base[2*k]   ^ (hit & ~idx_cur[k]);
    end
  endgenerate

  assign col_nxt = col_base ^ (take ? data_i : 8'h00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q     <= 1'b0;
      idx_q      <= '0;
      row_q      <= '0;
      col_q      <= 8'h00;
      row_code_q <= '0;
      col_code_q <= 8'h00;
      done_q     <= 1'b0;
    end else begin
      done_q <= last;
      if (start_i | take) begin
        row_q <= row_nxt;
        col_q <= col_nxt;
      end
      if (take)         idx_q <= idx_cur + 1'b1;
      else if (start_i) idx_q <= '0;
      if (last)         open_q <= 1'b0;
      else if (start_i) open_q <= 1'b1;
      if (last) begin
        row_code_q <= row_nxt;
        col_code_q <= fold_col(col_nxt);
      end
    end
  end

  assign done_o     = done_q;
  assign row_code_o = row_code_q;
  assign col_code_o = col_code_q;

endmodule

module nand_hamming_gen_chk #(
  parameter int IDX_BITS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start_i,
  input logic                  valid_i,
  input logic                  done_o,
  input logic [2*IDX_BITS-1:0] row_code_o,
  input logic [7:0]            col_code_o
);
  localparam int FULL = 1 << IDX_BITS;

  logic [IDX_BITS:0]   cnt;
  logic                act;
  logic [IDX_BITS-1:0] pair_x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      act <= 1'b0;
    end else if (start_i) begin
      cnt <= valid_i ? (IDX_BITS+1)'(1) : '0;
      act <= 1'b1;
    end else if (act && valid_i) begin
      cnt <= cnt + 1'b1;
      if (cnt == (IDX_BITS+1)'(FULL - 1)) act <= 1'b0;
    end
  end

  genvar k;
  generate
    for (k = 0; k < IDX_BITS; k++) begin : g_pair
      assign pair_x[k] = row_code_o[2*k] ^ row_code_o[2*k+1];
    end
  endgenerate

  // R7
  done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R7
  done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cnt == (IDX_BITS+1)'(FULL)));
  // R7
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && valid_i && !start_i && cnt == (IDX_BITS+1)'(FULL - 1)) |=> done_o);
  // R8
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(row_code_o) && $stable(col_code_o)));
  // R3
  col_bit1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_code_o[1] == 1'b0);
  // R3
  col_overall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_code_o[0] == (col_code_o[7] ^ col_code_o[6])) &&
    (col_code_o[0] == (col_code_o[5] ^ col_code_o[4])) &&
    (col_code_o[0] == (col_code_o[3] ^ col_code_o[2])));
  // R1
  row_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_x == {IDX_BITS{col_code_o[0]}});
endmodule

bind nand_hamming_gen nand_hamming_gen_chk #(.IDX_BITS(IDX_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
  .done_o(done_o), .row_code_o(row_code_o), .col_code_o(col_code_o)
);

// File: tb/sim_nand_hamming_gen.sv
`timescale 1ns/1ps
module sim_nand_hamming_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  data_i = 8'h00;
  logic        done_o;
  logic [15:0] row_code_o;
  logic [7:0]  col_code_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] mem [256];
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  nand_hamming_gen #(.IDX_BITS(8)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
    .data_i(data_i), .done_o(done_o), .row_code_o(row_code_o),
    .col_code_o(col_code_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] model();
    logic [15:0] r = '0;
    logic [7:0]  c = '0;
    logic [7:0]  cc;
    for (int i = 0; i < 256; i++)
      for (int b = 0; b < 8; b++)
        if (mem[i][b]) begin
          c[b] = ~c[b];
          for (int k = 0; k < 8; k++) begin
            if (i[k]) r[2*k+1] = ~r[2*k+1];
            else      r[2*k]   = ~r[2*k];
          end
        end
    cc[7] = $countones(c & 8'hF0) % 2 == 1;
    cc[6] = $countones(c & 8'h0F) % 2 == 1;
    cc[5] = $countones(c & 8'hCC) % 2 == 1;
    cc[4] = $countones(c & 8'h33) % 2 == 1;
    cc[3] = $countones(c & 8'hAA) % 2 == 1;
    cc[2] = $countones(c & 8'h55) % 2 == 1;
    cc[1] = 1'b0;
    cc[0] = $countones(c) % 2 == 1;
    return {cc, r};
  endfunction

  function automatic logic [7:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[23:16];
  endfunction

  // sep_start: lone start strobe first; gap: idle cycle with junk every gap bytes
  task automatic run_block(input string req, input int gap, input bit sep_start);
    int early = 0;
    logic [23:0] got;
    if (sep_start) begin
      start_i = 1'b1; valid_i = 1'b0; data_i = 8'h5A;
      @(negedge clk);
    end
    for (int i = 0; i < 256; i++) begin
      if (gap != 0 && i % gap == 3) begin
        start_i = 1'b0; valid_i = 1'b0; data_i = 8'hA5 ^ 8'(i);
        @(negedge clk);
        if (done_o) early++;
      end
      start_i = (i == 0) && !sep_start;
      valid_i = 1'b1;
      data_i  = mem[i];
      @(negedge clk);
      if (done_o && i != 255) early++;
    end
    start_i = 1'b0; valid_i = 1'b0; data_i = 8'h00;
    check({req, " R7 no early done"}, early, 0);
    check({req, " R7 done after last byte"}, {31'b0, done_o}, 1);
    check({req, " code"}, {8'h0, col_code_o, row_code_o}, {8'h0, model()});
    got = {col_code_o, row_code_o};
    @(negedge clk);
    check({req, " R7 done one cycle"}, {31'b0, done_o}, 0);
    check({req, " R8 code holds"}, {8'h0, col_code_o, row_code_o}, {8'h0, got});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] held;
    int extra_done;
    repeat (3) @(negedge clk);
    // R10
    check("R10 done after reset", {31'b0, done_o}, 0);
    check("R10 code after reset", {8'h0, col_code_o, row_code_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 code after release", {8'h0, col_code_o, row_code_o}, 0);

    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    run_block("R4 all ones", 0, 0);
    check("R4 all ones gives zero", {8'h0, col_code_o, row_code_o}, 0);

    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    run_block("R4 all zeros", 0, 0);

    for (int i = 0; i < 256; i++) mem[i] = 8'(i);
    run_block("R1 R2 R3 ramp", 0, 0);

    // R1 R2: single set bit swept over every index, lane rotating
    for (int p = 0; p < 256; p++) begin
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      mem[p] = 8'h01 << (p % 8);
      run_block("R1 R2 single bit", 0, 0);
    end

    // R6: idle gaps carrying junk
    for (int n = 0; n < 4; n++) begin
      for (int i = 0; i < 256; i++) mem[i] = rnd();
      run_block("R6 gaps", 5 + n, 0);
    end

    // R9: bytes after completion without start
    held = {col_code_o, row_code_o};
    extra_done = 0;
    for (int i = 0; i < 300; i++) begin
      valid_i = 1'b1; data_i = rnd();
      @(negedge clk);
      if (done_o) extra_done++;
    end
    valid_i = 1'b0;
    @(negedge clk);
    check("R9 no done without start", extra_done, 0);
    check("R9 R8 code unchanged", {8'h0, col_code_o, row_code_o}, {8'h0, held});

    // R5: lone start strobe
    for (int i = 0; i < 256; i++) mem[i] = rnd();
    run_block("R5 lone start", 0, 1);

    // R11: partial block abandoned by restart
    held = {col_code_o, row_code_o};
    for (int i = 0; i < 100; i++) begin
      start_i = (i == 0); valid_i = 1'b1; data_i = rnd();
      @(negedge clk);
    end
    start_i = 1'b0; valid_i = 1'b0;
    check("R11 R8 code held in partial block", {8'h0, col_code_o, row_code_o}, {8'h0, held});
    for (int i = 0; i < 256; i++) mem[i] = rnd();
    run_block("R11 restart", 0, 0);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule